// File: doc/BRIEF.md
# Ternary Priority Lookup Table

This block is a small lookup table searched by content rather than by address. Each of its N entries holds a pattern of W positions. Every position is a 0, a 1 or a don't-care, so one entry can stand for many keys. Each entry also carries a result field, such as an output port number. A write port loads the pattern and result of one entry at a chosen index. A search key is presented on every cycle. One clock later the block reports whether any entry matched, the index of the winning entry and that entry's result.

Each position of a pattern is stored as two bits. When several entries match the same key, the one at the lowest index wins. A typical use is routing: exact entries sit at low indices, wider prefix entries sit above them, and an all-don't-care default entry is placed last.

Top module: `tcam_lookup`

## Requirements
- R1: After reset every entry is invalid, so every key misses until an entry is written.
- R2: A position coded 01 (bit 2i+1 = 0, bit 2i = 1 of the pattern word, position i) matches only key bit i = 0. A position coded 10 matches only key bit i = 1.
- R3: A position coded 00 matches either value of its key bit.
- R4: A position coded 11 never matches, so an entry that contains it can never be selected.
- R5: An entry matches only when every position that is not a don't-care equals the corresponding key bit.
- R6: When several entries match, the lowest index is reported.
- R7: On a hit, the index output gives the winning entry and the result output gives the result field stored with that entry.
- R8: The outcome of a search appears on the outputs one clock after its key is presented. A write at index j in cycle t is seen by searches presented from cycle t+1 onward. A search presented in cycle t still sees the old contents of index j.
- R9: When no entry matches, the hit flag is 0 and the index and result outputs are both 0.
- R10: An entry whose positions are all don't-care matches every key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | $clog2(N) | Index of the entry to load |
| wr_code | input | 2*W | Pattern, two bits per position, position i at bits 2i+1:2i |
| wr_result | input | RW | Result field stored with the entry |
| key | input | W | Search key, searched every cycle |
| hit_o | output | 1 | Registered: some entry matched the previous key |
| hit_idx_o | output | $clog2(N) | Registered index of the winning entry, 0 on miss |
| hit_result_o | output | RW | Registered result of the winning entry, 0 on miss |

## Verification
The assertions assume that write indices stay below N. They also assume that the result registers track the key and contents of the cycle just before, counted from the first cycle after reset is released. The bench therefore writes only indices 0 to N-1. It holds reset until the contents are defined and compares outputs one cycle after each key. In each table state it sweeps every possible key of a narrow configuration, including a key presented on the same cycle as a write.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    TRIT_ANY  = 2'b00,
    TRIT_ZERO = 2'b01,
    TRIT_ONE  = 2'b10,
    TRIT_VOID = 2'b11
  } trit_e;

  function automatic logic trit_accepts(input trit_e t, input logic kbit);
    case (t)
      TRIT_ANY:  return 1'b1;
      TRIT_ZERO: return ~kbit;
      TRIT_ONE:  return kbit;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int RW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = 2 * W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [CW-1:0]   wr_code,
  input  logic [RW-1:0]   wr_result,
  output logic [N*CW-1:0] code_flat,
  output logic [N*RW-1:0] result_flat
);
  logic [CW-1:0] code_q [N];
  logic [RW-1:0] res_q  [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        code_q[i] <= '1;
        res_q[i]  <= '0;
      end
    end else if (wr_en && (int'(wr_idx) < N)) begin
      code_q[wr_idx] <= wr_code;
      res_q[wr_idx]  <= wr_result;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign code_flat[g*CW +: CW]   = code_q[g];
    assign result_flat[g*RW +: RW] = res_q[g];
  end

  // R8: a write has landed in the entry by the following cycle
  p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |->
      (code_flat[$past(wr_idx)*CW +: CW] == $past(wr_code)));
endmodule

// File: rtl/tcam_row_match.sv
module tcam_row_match
  import tcam_pkg::*;
#(
  parameter int W = 8,
  localparam int CW = 2 * W
) (
  input  logic [CW-1:0] code,
  input  logic [W-1:0]  key,
  output logic          match
);
  logic [W-1:0] pos_ok;

  for (genvar i = 0; i < W; i++) begin : g_pos
    assign pos_ok[i] = trit_accepts(trit_e'(code[2*i +: 2]), key[i]);
  end

  // match line stays high only if no position pulls it low
  assign match = &pos_ok;
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int RW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [CW-1:0] wr_code,
  input  logic [RW-1:0] wr_result,
  input  logic [W-1:0]  key,
  output logic          hit_o,
  output logic [IW-1:0] hit_idx_o,
  output logic [RW-1:0] hit_result_o
);
  logic [N*CW-1:0] code_flat;
  logic [N*RW-1:0] res_flat;
  logic [N-1:0]    row_match;
  logic            win_any;
  logic [IW-1:0]   win_idx;
  logic [RW-1:0]   win_res;

  tcam_entry_store #(.N(N), .W(W), .RW(RW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_code(wr_code), .wr_result(wr_result),
    .code_flat(code_flat), .result_flat(res_flat)
  );

  for (genvar e = 0; e < N; e++) begin : g_row
    tcam_row_match #(.W(W)) u_row (
      .code(code_flat[e*CW +: CW]), .key(key), .match(row_match[e])
    );
  end

  tcam_prio_enc #(.N(N)) u_prio (
    .req(row_match), .any(win_any), .idx(win_idx)
  );

  assign win_res = res_flat[win_idx*RW +: RW];

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o        <= 1'b0;
      hit_idx_o    <= '0;
      hit_result_o <= '0;
    end else begin
      hit_o        <= win_any;
      hit_idx_o    <= win_any ? win_idx : '0;
      hit_result_o <= win_any ? win_res : '0;
    end
  end

  // R9: a miss drives zero on index and result
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (hit_idx_o == '0 && hit_result_o == '0));

  // R8: hit flag reflects the match lines of the previous cycle
  p_hit_follows_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hit_o == (|$past(row_match))));

  // R6: reported entry matched and no lower entry matched
  p_lowest_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hit_o) |->
      ((($past(row_match) >> hit_idx_o) & N'(1)) == N'(1) &&
       ($past(row_match) & ((N'(1) << hit_idx_o) - N'(1))) == '0));

  // R7: reported result is the one stored with the reported entry
  p_result_pairs_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hit_o) |->
      (hit_result_o == RW'($past(res_flat) >> (hit_idx_o * RW))));
endmodule

// File: tb/tb_tcam_lookup.sv
`timescale 1ns/1ps
module tb_tcam_lookup;
  localparam int N  = 4;
  localparam int W  = 4;
  localparam int RW = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [2*W-1:0] wr_code = '0;
  logic [RW-1:0] wr_result = '0;
  logic [W-1:0]  key = '0;
  logic          hit_o;
  logic [IW-1:0] hit_idx_o;
  logic [RW-1:0] hit_result_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [2*W-1:0] m_code [N];
  logic [RW-1:0]  m_res  [N];

  always #5 clk = ~clk;

  tcam_lookup #(.N(N), .W(W), .RW(RW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_code(wr_code), .wr_result(wr_result), .key(key),
    .hit_o(hit_o), .hit_idx_o(hit_idx_o), .hit_result_o(hit_result_o)
  );

  // pattern from care mask and value: cared 1 -> 10, cared 0 -> 01, else 00
  function automatic logic [2*W-1:0] pat(input logic [W-1:0] care, input logic [W-1:0] val);
    logic [2*W-1:0] c = '0;
    for (int i = 0; i < W; i++)
      if (care[i]) c[2*i +: 2] = val[i] ? 2'b10 : 2'b01;
    return c;
  endfunction

  function automatic logic [1+IW+RW-1:0] expect_of(input logic [W-1:0] k);
    for (int e = 0; e < N; e++) begin
      bit ok = 1;
      for (int i = 0; i < W; i++) begin
        case (m_code[e][2*i +: 2])
          2'b00: ;
          2'b01: if (k[i] != 1'b0) ok = 0;
          2'b10: if (k[i] != 1'b1) ok = 0;
          default: ok = 0;
        endcase
      end
      if (ok) return {1'b1, IW'(e), m_res[e]};
    end
    return '0;
  endfunction

  task automatic compare(input string tag, input logic [W-1:0] k, input logic [1+IW+RW-1:0] exp);
    checks++;
    if ({hit_o, hit_idx_o, hit_result_o} !== exp) begin
      fails++;
      $display("FAIL %s key=%b got hit=%b idx=%0d res=%0d exp hit=%b idx=%0d res=%0d",
               tag, k, hit_o, hit_idx_o, hit_result_o,
               exp[IW+RW], exp[RW +: IW], exp[RW-1:0]);
    end
  endtask

  task automatic do_write(input int idx, input logic [2*W-1:0] c, input logic [RW-1:0] r);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_code = c; wr_result = r;
    @(negedge clk);
    wr_en = 1'b0;
    m_code[idx] = c; m_res[idx] = r;
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < (1 << W); k++) begin
      logic [1+IW+RW-1:0] exp;
      @(negedge clk);
      key = W'(k);
      exp = expect_of(W'(k));
      @(negedge clk);
      compare(tag, W'(k), exp);
    end
  endtask

  initial begin
    for (int e = 0; e < N; e++) begin m_code[e] = '1; m_res[e] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 reset outputs", key, '0);
    sweep("R1/R9 empty table miss");
    // exact entry 1010 at index 1
    do_write(1, pat(4'b1111, 4'b1010), 4'd5);
    sweep("R2/R5 exact entry");
    // entry 3: only bits 1:0 cared, value 10
    do_write(3, pat(4'b0011, 4'b0010), 4'd11);
    sweep("R3/R6 partial entry below exact one");
    // entry 0 explicitly invalid
    do_write(0, '1, 4'd7);
    sweep("R4 invalid code never selected");
    // entry 0 with one invalid position, others don't-care
    do_write(0, {6'b000000, 2'b11}, 4'd7);
    sweep("R4 single void position");
    // entry 2 all don't-care default
    do_write(2, '0, 4'd9);
    sweep("R10/R6/R7 default entry");
    // R8: write and search in the same cycle
    @(negedge clk);
    key = 4'b0000;
    wr_en = 1'b1; wr_idx = 2'd0; wr_code = '0; wr_result = 4'd3;
    @(negedge clk);
    wr_en = 1'b0;
    compare("R8 same-cycle search sees old contents", key, {1'b1, 2'd2, 4'd9});
    m_code[0] = '0; m_res[0] = 4'd3;
    @(negedge clk);
    compare("R8 next search sees new contents", key, {1'b1, 2'd0, 4'd3});
    sweep("R7/R10 default at index 0");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule